// File: doc/BRIEF.md
# PCI Target Termination Controller

This block chooses how each transaction aimed at the device's target side ends. It watches a reduced target handshake: FRAME and IRDY from the initiator, a two-bit cycle class, and a ready strobe from the slow internal data source. From these it drives the active-low DEVSEL, TRDY and STOP strobes. The result is one of three endings. A cycle ends in a normal completion when data turns up in time. It ends in a disconnect when a busy source is active as the cycle is claimed. It ends in a retry when sixteen clocks pass without data.

The block holds the I/O and memory claim enables, which a hard reset clears. It also runs the start-and-busy handshake of the configuration EEPROM loader. A load begins on its own after hard reset and can be started again by the host through a control word. While that load runs, or while a blocking PHY register read is in progress, every claimed cycle is disconnected. Right after reset no I/O or memory cycle is claimed, so only configuration cycles reach that disconnect.

Top module: `pci_tgt_term_ctrl`

## Requirements
- R1: During and right after reset, `devsel_n`, `trdy_n` and `stop_n` are high, `prom_busy` is low, and both claim enables are cleared.
- R2: `cyc_type` encodes 00 = configuration, 01 = I/O, 10 = memory, 11 = reserved. Configuration cycles are always claimed. I/O cycles are claimed only when enable bit 0 is set, and memory cycles only when enable bit 1 is set. Reserved cycles are never claimed. An unclaimed cycle leaves `devsel_n` high until it ends.
- R3: For a claimed cycle with no busy source, `devsel_n` goes low on the clock edge that samples `frame_n` low. If `data_ready` is sampled high at the j-th later edge (1 to 16), `trdy_n` goes low with `stop_n` high from that edge on.
- R4: If a claimed, non-busy cycle sees no `data_ready` during the 16 edges after the claim edge, `stop_n` goes low at the 16th edge while `trdy_n` stays high and `devsel_n` stays low.
- R5: When `data_ready` arrives on the same edge at which the 16-clock limit expires, the cycle completes normally rather than retrying.
- R6: If `prom_busy` or `phy_busy` is high at the claim edge, the claimed cycle is disconnected from that edge on: `devsel_n` and `stop_n` low, `trdy_n` high.
- R7: Once a termination has been signalled, the strobes hold until `frame_n` and `irdy_n` are both sampled high. At that edge all three strobes return high.
- R8: On the first clock after reset is released, `prom_start` pulses for one clock and `prom_busy` rises. `prom_busy` falls at the edge that samples `prom_done` high.
- R9: A write on `ctl_wr` with bit 14 of `ctl_wdata` set starts a new load (a `prom_start` pulse and `prom_busy` high) when no load is running. A write with bit 14 clear, or any write while a load is running, produces no start.
- R10: `cmd_wr` loads the claim enables from `cmd_wdata` (bit 0 I/O, bit 1 memory). During the load that starts after reset, an I/O cycle is ignored while a configuration cycle is disconnected.
- R11: The 16-clock limit restarts for every cycle, so a second cycle gets the full window no matter how the one before it ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low hard reset |
| frame_n | input | 1 | Initiator FRAME, active low |
| irdy_n | input | 1 | Initiator IRDY, active low |
| cyc_type | input | 2 | Cycle class of the current transaction |
| data_ready | input | 1 | Internal data ready for this cycle |
| phy_busy | input | 1 | Blocking PHY register read in progress |
| cmd_wr | input | 1 | Write strobe for the claim enables |
| cmd_wdata | input | 2 | New claim enables (bit 0 I/O, bit 1 memory) |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 16 | Control word; bit 14 requests an EEPROM load |
| prom_done | input | 1 | EEPROM loader finished |
| prom_start | output | 1 | One-clock start pulse to the EEPROM loader |
| prom_busy | output | 1 | EEPROM load in progress |
| devsel_n | output | 1 | DEVSEL, active low |
| trdy_n | output | 1 | TRDY, active low |
| stop_n | output | 1 | STOP, active low |

## Verification
Every strobe is registered, so the claim response appears at the edge that first samples FRAME low. A completion appears at the edge that samples `data_ready`, a retry at the 16th edge after the claim, and the release to all-high at the edge that samples the bus idle. Loader `prom_start` and `prom_busy` change at the edge that samples the triggering write, reset release or `prom_done`. The transaction driver works out these edge numbers from the requirements when it issues a cycle and queues the expected strobe values under their edge numbers. A monitor samples at each falling edge and compares every queued entry whose edge has just passed.

// File: rtl/pci_term_pkg.sv
package pci_term_pkg;

    typedef enum logic [1:0] {
        CYC_CFG  = 2'b00,
        CYC_IO   = 2'b01,
        CYC_MEM  = 2'b10,
        CYC_RSVD = 2'b11
    } cyc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SKIP,
        ST_WAIT,
        ST_DONE,
        ST_DISC,
        ST_RETRY
    } term_state_e;

    typedef struct packed {
        term_state_e st;
        logic        devsel_n;
        logic        trdy_n;
        logic        stop_n;
    } term_regs_t;

    typedef struct packed {
        logic req;
        logic start;
        logic busy;
    } load_regs_t;

    typedef struct packed {
        logic io_en;
        logic mem_en;
    } claim_en_t;

endpackage

// File: rtl/prom_load_seq.sv
module prom_load_seq
    import pci_term_pkg::*;
#(
    parameter int CTL_W    = 16,
    parameter int LOAD_BIT = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             prom_done,
    output logic             prom_start,
    output logic             prom_busy
);

    load_regs_t cur_q, nxt_d;
    logic       host_req;
    logic       unused_ctl;

    assign host_req   = ctl_wr & ctl_wdata[LOAD_BIT];
    assign unused_ctl = ^ctl_wdata;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.req   = 1'b0;
        nxt_d.start = (cur_q.req | host_req) & ~cur_q.busy;
        if (nxt_d.start) begin
            nxt_d.busy = 1'b1;
        end else if (prom_done) begin
            nxt_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{req: 1'b1, start: 1'b0, busy: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign prom_start = cur_q.start;
    assign prom_busy  = cur_q.busy;

    // R8: busy only rises together with a start pulse
    assert_busy_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prom_busy) |-> prom_start);

    // R9: no new start while a load was already running
    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(prom_busy) |-> !prom_start);

endmodule

// File: rtl/tgt_wait_timer.sv
module tgt_wait_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = run && (cnt_q == LAST);

    // R11: counter starts from zero whenever a wait begins
    assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> (cnt_q == '0));

endmodule

// File: rtl/tgt_term_fsm.sv
module tgt_term_fsm
    import pci_term_pkg::*;
#(
    parameter int TIMEOUT_CLKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic irdy_n,
    input  logic claim,
    input  logic busy,
    input  logic data_ready,
    output logic devsel_n,
    output logic trdy_n,
    output logic stop_n
);

    term_regs_t cur_q, nxt_d;
    logic       bus_end;
    logic       expired;
    logic       waiting;

    assign bus_end = frame_n & irdy_n;
    assign waiting = (cur_q.st == ST_WAIT);

    tgt_wait_timer #(.LIMIT(TIMEOUT_CLKS)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (waiting),
        .expired (expired)
    );

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (!frame_n) begin
                    if (!claim)     nxt_d.st = ST_SKIP;
                    else if (busy)  nxt_d.st = ST_DISC;
                    else            nxt_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (bus_end)         nxt_d.st = ST_IDLE;
                else if (data_ready) nxt_d.st = ST_DONE;
                else if (expired)    nxt_d.st = ST_RETRY;
            end
            default: begin
                if (bus_end) nxt_d.st = ST_IDLE;
            end
        endcase
        nxt_d.devsel_n = !(nxt_d.st inside {ST_WAIT, ST_DONE, ST_DISC, ST_RETRY});
        nxt_d.trdy_n   = !(nxt_d.st == ST_DONE);
        nxt_d.stop_n   = !(nxt_d.st inside {ST_DISC, ST_RETRY});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, devsel_n: 1'b1, trdy_n: 1'b1, stop_n: 1'b1};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign devsel_n = cur_q.devsel_n;
    assign trdy_n   = cur_q.trdy_n;
    assign stop_n   = cur_q.stop_n;

    // R2: an unclaimed cycle never raises DEVSEL
    assert_no_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_IDLE && !frame_n && !claim) |=> devsel_n);

    // R3: completion and stop never coexist
    assert_trdy_stop_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!trdy_n && !stop_n));

    // R4: timer expiry without data yields a retry
    assert_timeout_retry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && expired && !data_ready && !bus_end) |=> (!stop_n && trdy_n && !devsel_n));

    // R5: data wins over a coincident expiry
    assert_data_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && data_ready && !bus_end) |=> (!trdy_n && stop_n));

    // R7: STOP held until the bus goes idle, then all strobes release
    assert_stop_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_n && !bus_end) |=> !stop_n);
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_end |=> (devsel_n && trdy_n && stop_n));

endmodule

// File: rtl/pci_tgt_term_ctrl.sv
module pci_tgt_term_ctrl
    import pci_term_pkg::*;
#(
    parameter int TIMEOUT_CLKS = 16,
    parameter int CTL_W        = 16,
    parameter int LOAD_BIT     = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic [1:0]       cyc_type,
    input  logic             data_ready,
    input  logic             phy_busy,
    input  logic             cmd_wr,
    input  logic [1:0]       cmd_wdata,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             prom_done,
    output logic             prom_start,
    output logic             prom_busy,
    output logic             devsel_n,
    output logic             trdy_n,
    output logic             stop_n
);

    claim_en_t en_q, en_d;
    logic      claim;
    logic      busy_any;

    always_comb begin
        en_d = en_q;
        if (cmd_wr) begin
            en_d.io_en  = cmd_wdata[0];
            en_d.mem_en = cmd_wdata[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    always_comb begin
        unique case (cyc_kind_e'(cyc_type))
            CYC_CFG:  claim = 1'b1;
            CYC_IO:   claim = en_q.io_en;
            CYC_MEM:  claim = en_q.mem_en;
            default:  claim = 1'b0;
        endcase
    end

    prom_load_seq #(.CTL_W(CTL_W), .LOAD_BIT(LOAD_BIT)) i_load (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .prom_done  (prom_done),
        .prom_start (prom_start),
        .prom_busy  (prom_busy)
    );

    assign busy_any = prom_busy | phy_busy;

    tgt_term_fsm #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n    (frame_n),
        .irdy_n     (irdy_n),
        .claim      (claim),
        .busy       (busy_any),
        .data_ready (data_ready),
        .devsel_n   (devsel_n),
        .trdy_n     (trdy_n),
        .stop_n     (stop_n)
    );

    // R6: a claimed cycle seen while busy is disconnected at once
    assert_busy_disc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (devsel_n && stop_n && trdy_n && !frame_n && claim && busy_any && !$past(!frame_n))
        |=> (!devsel_n && !stop_n && trdy_n));

    // R4: STOP is only ever driven with DEVSEL
    assert_stop_with_devsel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_n |-> !devsel_n);

endmodule

// File: tb/test_pci_tgt_term_ctrl.sv
module test_pci_tgt_term_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_n, irdy_n;
    logic [1:0]  cyc_type;
    logic        data_ready, phy_busy;
    logic        cmd_wr;
    logic [1:0]  cmd_wdata;
    logic        ctl_wr;
    logic [15:0] ctl_wdata;
    logic        prom_done;
    logic        prom_start, prom_busy;
    logic        devsel_n, trdy_n, stop_n;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit ended  = 0;

    typedef struct {
        int         at;
        logic [2:0] pins;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pci_tgt_term_ctrl i_pci_tgt_term_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .cyc_type(cyc_type), .data_ready(data_ready), .phy_busy(phy_busy),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .ctl_wr(ctl_wr),
        .ctl_wdata(ctl_wdata), .prom_done(prom_done), .prom_start(prom_start),
        .prom_busy(prom_busy), .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: compare queued expectations once their edge has passed
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (e.at != cyc || {devsel_n, trdy_n, stop_n} !== e.pins) begin
                fails++;
                $display("FAIL %s: edge %0d actual %b expected %b (devsel,trdy,stop)",
                         e.tag, cyc, {devsel_n, trdy_n, stop_n}, e.pins);
            end
        end
    end

    task automatic push(input int at, input logic [2:0] pins, input string tag);
        exp_t e;
        e.at = at; e.pins = pins; e.tag = tag;
        sb.push_back(e);
    endtask

    // driver: one bus cycle; expected strobes derived from the requirements
    task automatic txn(input logic [1:0] ty, input bit claimed, input bit busy,
                       input int rdy_at, input int len, input string tag);
        int k;
        int ts;
        logic [2:0] term;
        k = cyc + 1;
        if (!claimed) begin
            push(k, 3'b111, tag);
            push(k + len - 1, 3'b111, tag);
        end else if (busy) begin
            push(k, 3'b010, tag);
            push(k + len - 1, 3'b010, tag);
        end else begin
            ts   = (rdy_at != 0 && rdy_at <= 16) ? rdy_at : 16;
            term = (rdy_at != 0 && rdy_at <= 16) ? 3'b001 : 3'b010;
            push(k, 3'b011, tag);
            if (ts > 1) push(k + ts - 1, 3'b011, tag);
            push(k + ts, term, tag);
            push(k + len - 1, term, tag);
        end
        push(k + len, 3'b111, {tag, " R7"});
        frame_n  = 1'b0;
        irdy_n   = 1'b0;
        cyc_type = ty;
        for (int i = 0; i < len; i++) begin
            data_ready = (rdy_at != 0 && i == rdy_at);
            @(negedge clk);
        end
        frame_n    = 1'b1;
        irdy_n     = 1'b1;
        data_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #100000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected finish");
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
        end
        $finish;
    end

    initial begin
        rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; cyc_type = 2'b00;
        data_ready = 1'b0; phy_busy = 1'b0; cmd_wr = 1'b0; cmd_wdata = 2'b00;
        ctl_wr = 1'b0; ctl_wdata = 16'h0; prom_done = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 strobes", {29'd0, devsel_n, trdy_n, stop_n}, 32'h7);
        chk("R1 busy", prom_busy, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 start pulse", prom_start, 1'b1);
        chk("R8 busy rise", prom_busy, 1'b1);
        @(negedge clk);
        chk("R8 pulse width", prom_start, 1'b0);
        chk("R8 busy hold", prom_busy, 1'b1);

        txn(2'b01, 0, 0, 0, 4, "R10 R1 io ignored");
        txn(2'b00, 1, 1, 0, 4, "R10 cfg disconnect");
        prom_done = 1'b1;
        @(negedge clk);
        prom_done = 1'b0;
        chk("R8 busy fall", prom_busy, 1'b0);

        cmd_wr = 1'b1; cmd_wdata = 2'b01;
        @(negedge clk);
        cmd_wr = 1'b0;
        txn(2'b10, 0, 0, 0, 3, "R2 mem disabled");
        txn(2'b11, 0, 0, 0, 3, "R2 reserved");
        txn(2'b01, 1, 0, 3, 6, "R3 io complete");
        txn(2'b00, 1, 0, 1, 4, "R3 cfg fast");
        txn(2'b01, 1, 0, 0, 19, "R4 timeout");
        txn(2'b01, 1, 0, 16, 19, "R5 tie");
        txn(2'b01, 1, 0, 15, 18, "R5 just in time");
        txn(2'b00, 1, 0, 0, 19, "R11 fresh window");

        cmd_wr = 1'b1; cmd_wdata = 2'b11;
        @(negedge clk);
        cmd_wr = 1'b0;
        phy_busy = 1'b1;
        txn(2'b10, 1, 1, 0, 5, "R6 phy disconnect");
        phy_busy = 1'b0;
        txn(2'b10, 1, 0, 2, 5, "R2 mem enabled");

        ctl_wr = 1'b1; ctl_wdata = 16'hBFFF;
        @(negedge clk);
        ctl_wr = 1'b0;
        chk("R9 bit14 clear", prom_start, 1'b0);
        ctl_wr = 1'b1; ctl_wdata = 16'h4000;
        @(negedge clk);
        ctl_wr = 1'b0;
        chk("R9 host start", prom_start, 1'b1);
        chk("R9 host busy", prom_busy, 1'b1);
        ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
        chk("R9 start while busy", prom_start, 1'b0);

        repeat (2) @(negedge clk);
        chk("R7 queue drained", sb.size(), 0);
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
        end
        $finish;
    end

endmodule